// File: doc/BRIEF.md
# Branch Execution Unit

This unit resolves control transfers in the execute stage of a three-stage, 32-bit pipelined core. It receives the instruction word and the execute-stage PC, which runs eight bytes ahead of the instruction's own address. It also receives a condition verdict from the flag logic and the contents of a register that the register file reads using a selector driven by this unit. From these it produces the address of the next instruction to run, a one-cycle write of the return address into the link register, and a pipeline flush followed by a refill stall.

Two encodings are recognised. The first is a relative jump, with or without a link write, whose signed word offset spans plus or minus 32 MB. The second is an indirect jump through a register. An instruction that is not a branch, or whose condition fails, falls through to the next word and causes no flush or stall. Instruction-set state switching, offset generation by the assembler and the register file itself sit outside the block.

Top module: `brx_unit`

## Requirements
- R1: While reset is held and right after it, `flush`, `pc_load` and `link_we` are 0, `ready` is 1 and `next_pc` is 0.
- R2: An instruction is accepted on a rising edge where `issue_valid` and `ready` are both 1. It is a relative jump when bits [27:25] equal 3'b101. If accepted with `cond_pass`=1, then from the next cycle `pc_load`=1 and `next_pc` = `pc_exec` + 4 × (bits [23:0] read as a signed 24-bit number), modulo 2^32.
- R3: The offset extremes work. Offset 24'h7FFFFF moves the PC by +33554428 bytes, and offset 24'h800000 moves it by −33554432 bytes.
- R4: When bit 24 is 1 on a taken relative jump, `link_we` pulses for exactly the cycle in which `pc_load` is 1, with `link_data` = `pc_exec` − 4.
- R5: When bit 24 is 0 on a relative jump, `link_we` stays 0 and `link_data` keeps its old value.
- R6: An indirect jump is recognised when bits [27:4] equal 24'h12FFF1. `reg_sel` shows bits [3:0] at all times. A taken indirect jump gives `next_pc` = `rm_value` with bit 0 cleared, and `link_we` stays 0.
- R7: A taken branch raises `flush` for one cycle. `ready` is 0 during that cycle and during the two refill cycles after it, and returns to 1 in the fourth cycle.
- R8: An issue presented while `ready` is 0 is ignored: `next_pc`, `pc_load`, `link_we` and `flush` do not respond to it.
- R9: An accepted instruction that has `cond_pass`=0, or that matches neither encoding, gives `next_pc` = `pc_exec` − 4, `pc_load`=0, `flush`=0 and `link_we`=0, and `ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction present in execute |
| instr | input | 32 | Instruction word |
| pc_exec | input | 32 | Execute-stage PC (instruction address + 8) |
| cond_pass | input | 1 | Condition field satisfied by current flags |
| rm_value | input | 32 | Register value for indirect jump |
| reg_sel | output | 4 | Register number for indirect jump read |
| next_pc | output | 32 | Address of the next instruction to execute |
| pc_load | output | 1 | Fetch must redirect to `next_pc` |
| link_we | output | 1 | Link register write enable |
| link_data | output | 32 | Return address for the link register |
| flush | output | 1 | Discard fetched and decoded instructions |
| ready | output | 1 | Unit accepts a new instruction |

## Verification
The bench sweeps the offset field with a walking one and a walking zero. This exposes a sign extension taken from the wrong bit, a missing ×4 scale and an off-by-eight PC base, each of which would send backward or long jumps to the wrong address. Both range extremes are checked exactly. Link values are checked against the instruction address plus four; an off-by-one-word return address would corrupt every subroutine return. The stall length is counted cycle by cycle, because one refill cycle too few would let a stale instruction execute. Branches with a failed condition, a near-miss indirect pattern and issues made during the stall must all leave the PC stream and the link register untouched.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_REL  = 2'd1,
    BRK_RELL = 2'd2,
    BRK_IND  = 2'd3
  } brk_kind_e;

  localparam logic [2:0]  REL_SIG = 3'b101;
  localparam logic [23:0] IND_SIG = 24'h12FFF1;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 24,
  parameter int RS_W  = 4
) (
  input  logic [XLEN-1:0]  instr,
  output brk_kind_e        kind,
  output logic [OFF_W-1:0] offset,
  output logic [RS_W-1:0]  reg_sel
);
  logic is_rel;
  logic is_ind;

  always_comb begin
    is_rel  = (instr[27:25] == REL_SIG);
    is_ind  = (instr[27:4] == IND_SIG);
    offset  = instr[OFF_W-1:0];
    reg_sel = instr[RS_W-1:0];
    if (is_rel) begin
      kind = instr[24] ? BRK_RELL : BRK_REL;
    end else if (is_ind) begin
      kind = BRK_IND;
    end else begin
      kind = BRK_NONE;
    end
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int OFF_W       = 24,
  parameter int PC_AHEAD    = 8,
  parameter int INSTR_BYTES = 4
) (
  input  brk_kind_e        kind,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0]  pc_exec,
  input  logic [XLEN-1:0]  rm_value,
  output logic [XLEN-1:0]  taken_pc,
  output logic [XLEN-1:0]  fall_pc
);
  localparam int SCALE_SH = $clog2(INSTR_BYTES);
  localparam int EXT_W    = XLEN - OFF_W - SCALE_SH;
  localparam logic [XLEN-1:0] BACK_STEP = XLEN'(PC_AHEAD - INSTR_BYTES);

  logic [XLEN-1:0] disp;

  always_comb begin
    disp    = {{EXT_W{offset[OFF_W-1]}}, offset, {SCALE_SH{1'b0}}};
    fall_pc = pc_exec - BACK_STEP;
    if (kind == BRK_IND) begin
      taken_pc = {rm_value[XLEN-1:1], 1'b0};
    end else begin
      taken_pc = pc_exec + disp;
    end
  end
endmodule

// File: rtl/brx_refill_ctl.sv
module brx_refill_ctl #(
  parameter int REFILL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic flush,
  output logic ready
);
  localparam int CNT_W = $clog2(REFILL_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REFILL_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flush_q, flush_d;

  always_comb begin
    cnt_d   = cnt_q;
    flush_d = 1'b0;
    if (start) begin
      cnt_d   = CNT_LOAD;
      flush_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flush_q <= flush_d;
    end
  end

  assign flush = flush_q;
  assign ready = (cnt_q == '0);
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter int OFF_W         = 24,
  parameter int RS_W          = 4,
  parameter int PC_AHEAD      = 8,
  parameter int INSTR_BYTES   = 4,
  parameter int REFILL_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     instr,
  input  logic [31:0]     pc_exec,
  input  logic            cond_pass,
  input  logic [31:0]     rm_value,
  output logic [3:0]      reg_sel,
  output logic [31:0]     next_pc,
  output logic            pc_load,
  output logic            link_we,
  output logic [31:0]     link_data,
  output logic            flush,
  output logic            ready
);
  brk_kind_e        kind;
  logic [OFF_W-1:0] offset;
  logic [RS_W-1:0]  sel;
  logic [XLEN-1:0]  taken_pc, fall_pc;
  logic             accept, take, link_en;

  logic [XLEN-1:0]  npc_q, npc_d;
  logic [XLEN-1:0]  lnk_q, lnk_d;
  logic             load_q, load_d;
  logic             lwe_q, lwe_d;

  brx_decode #(.XLEN(XLEN), .OFF_W(OFF_W), .RS_W(RS_W)) u_dec (
    .instr   (instr),
    .kind    (kind),
    .offset  (offset),
    .reg_sel (sel)
  );

  brx_target #(.XLEN(XLEN), .OFF_W(OFF_W), .PC_AHEAD(PC_AHEAD),
               .INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .kind     (kind),
    .offset   (offset),
    .pc_exec  (pc_exec),
    .rm_value (rm_value),
    .taken_pc (taken_pc),
    .fall_pc  (fall_pc)
  );

  brx_refill_ctl #(.REFILL_CYCLES(REFILL_CYCLES)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .flush (flush),
    .ready (ready)
  );

  always_comb begin
    accept  = issue_valid && ready;
    take    = accept && cond_pass && (kind != BRK_NONE);
    link_en = take && (kind == BRK_RELL);
    npc_d   = npc_q;
    lnk_d   = lnk_q;
    load_d  = take;
    lwe_d   = link_en;
    if (accept) begin
      npc_d = take ? taken_pc : fall_pc;
    end
    if (link_en) begin
      lnk_d = fall_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q  <= '0;
      lnk_q  <= '0;
      load_q <= 1'b0;
      lwe_q  <= 1'b0;
    end else begin
      npc_q  <= npc_d;
      lnk_q  <= lnk_d;
      load_q <= load_d;
      lwe_q  <= lwe_d;
    end
  end

  assign reg_sel   = sel;
  assign next_pc   = npc_q;
  assign link_data = lnk_q;
  assign pc_load   = load_q;
  assign link_we   = lwe_q;
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [31:0] next_pc,
  input logic [31:0] link_data,
  input logic        pc_load,
  input logic        link_we,
  input logic        flush,
  input logic        ready
);
  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!flush && !pc_load && !link_we && ready));
  // R4
  p_link_with_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> pc_load);
  // R5
  p_link_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !link_we |-> $stable(link_data));
  // R7
  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  p_flush_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!ready && pc_load));
  p_refill_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ready);
  // R8
  p_stall_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (!flush && !link_we && $stable(next_pc)));
endmodule

bind brx_unit brx_unit_chk i_brx_unit_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .next_pc     (next_pc),
  .link_data   (link_data),
  .pc_load     (pc_load),
  .link_we     (link_we),
  .flush       (flush),
  .ready       (ready)
);

// File: tb/test_brx_unit.sv
module test_brx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] instr, pc_exec, rm_value;
  logic        cond_pass;
  logic [3:0]  reg_sel;
  logic [31:0] next_pc, link_data;
  logic        pc_load, link_we, flush, ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  brx_unit i_brx_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .pc_exec(pc_exec), .cond_pass(cond_pass), .rm_value(rm_value),
    .reg_sel(reg_sel), .next_pc(next_pc), .pc_load(pc_load),
    .link_we(link_we), .link_data(link_data), .flush(flush), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rel_target(input logic [31:0] pc, input logic [23:0] off);
    int soff;
    soff = int'(off);
    if (soff >= 8388608) soff = soff - 16777216;
    return pc + 32'(soff * 4);
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                       input logic cp, input logic [31:0] rv);
    @(negedge clk);
    instr = ins; pc_exec = pc; cond_pass = cp; rm_value = rv;
    issue_valid = 1'b1;
    @(posedge clk);
    #1 issue_valid = 1'b0;
  endtask

  // After a taken issue: count stall cycles, R7
  task automatic check_stall();
    int lows = 0;
    chk("R7 flush", {31'd0, flush}, 32'd1);
    for (int c = 0; c < 6 && !ready; c++) begin
      lows++;
      @(posedge clk); #1;
      if (c == 0) chk("R7 flush drops", {31'd0, flush}, 32'd0);
    end
    chk("R7 not-ready cycles", lows, 3);
  endtask

  task automatic rel_case(input logic [23:0] off, input logic [31:0] pc, input logic lnk);
    logic [31:0] old_link;
    old_link = link_data;
    issue({4'hE, 3'b101, lnk, off}, pc, 1'b1, 32'h0);
    chk("R2 target", next_pc, rel_target(pc, off));
    chk("R2 load", {31'd0, pc_load}, 32'd1);
    if (lnk) begin
      chk("R4 link we", {31'd0, link_we}, 32'd1);
      chk("R4 link data", link_data, pc - 32'd4);
    end else begin
      chk("R5 no link we", {31'd0, link_we}, 32'd0);
      chk("R5 link kept", link_data, old_link);
    end
    check_stall();
  endtask

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; pc_exec = '0;
    cond_pass = 1'b0; rm_value = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flush", {31'd0, flush}, 32'd0);
    chk("R1 ready", {31'd0, ready}, 32'd1);
    chk("R1 next_pc", next_pc, 32'd0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", {29'd0, flush, pc_load, link_we}, 32'd0);

    // R2/R4/R5 walking one and walking zero offsets
    for (int b = 0; b < 24; b++) begin
      rel_case(24'(1 << b), 32'h0400_0008 + 32'(b * 16), b[0]);
      rel_case(~24'(1 << b), 32'h0400_1008 + 32'(b * 16), ~b[0]);
    end

    // R3 range extremes
    rel_case(24'h7FFFFF, 32'h1000_0008, 1'b0);
    chk("R3 max forward", next_pc - 32'h1000_0008, 32'd33554428);
    rel_case(24'h800000, 32'h1000_0008, 1'b1);
    chk("R3 max backward", 32'h1000_0008 - next_pc, 32'd33554432);

    // R6 indirect jump
    for (int r = 0; r < 16; r++) begin
      logic [31:0] rv, old_link;
      rv = 32'h2000_0001 + 32'(r * 32'h1111);
      old_link = link_data;
      instr = {4'hE, 24'h12FFF1, 4'(r)};
      #1 chk("R6 reg_sel", {28'd0, reg_sel}, 32'(r));
      issue({4'hE, 24'h12FFF1, 4'(r)}, 32'h3000_0008, 1'b1, rv);
      chk("R6 target", next_pc, rv & ~32'd1);
      chk("R6 no link", {31'd0, link_we}, 32'd0);
      chk("R6 link kept", link_data, old_link);
      check_stall();
    end

    // R9 condition failed, non-branch, near-miss indirect pattern
    begin
      logic [31:0] pats [4];
      pats[0] = {4'h0, 3'b101, 1'b1, 24'h000010};
      pats[1] = {4'hE, 24'h12FFF1, 4'h3};
      pats[2] = {4'hE, 24'h12FFF3, 4'h3};
      pats[3] = 32'hE1A0_0001;
      for (int k = 0; k < 4; k++) begin
        logic [31:0] old_link;
        old_link = link_data;
        issue(pats[k], 32'h5000_0108 + 32'(k * 4), (k >= 2), 32'h7777_7777);
        chk("R9 fall pc", next_pc, 32'h5000_0104 + 32'(k * 4));
        chk("R9 no load/flush/link", {29'd0, pc_load, flush, link_we}, 32'd0);
        chk("R9 ready", {31'd0, ready}, 32'd1);
        chk("R9 link kept", link_data, old_link);
      end
    end

    // R8 issue during stall is ignored
    begin
      logic [31:0] held, old_link;
      issue({4'hE, 3'b101, 1'b0, 24'h000100}, 32'h6000_0008, 1'b1, 32'h0);
      held = next_pc;
      old_link = link_data;
      @(negedge clk);
      instr = {4'hE, 3'b101, 1'b1, 24'h000020}; pc_exec = 32'h7000_0008;
      cond_pass = 1'b1; issue_valid = 1'b1;
      for (int c = 0; c < 2; c++) begin
        @(posedge clk); #1;
        chk("R8 pc held", next_pc, held);
        chk("R8 no flush/link", {30'd0, flush, link_we}, 32'd0);
      end
      issue_valid = 1'b0;
      chk("R8 link kept", link_data, old_link);
      @(posedge clk); #1;
      chk("R8 ready again", {31'd0, ready}, 32'd1);
    end

    done = 1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule